// File: doc/BRIEF.md
# Stacked Repeater Bus Arbiter

This block decides which of several stacked hub devices may put data on a shared expansion bus between repeaters. Each device raises a request when its local repeater has traffic for the stack. One device in the stack is strapped as master. The master's arbiter gathers its own request and three request lines from the other units. It grants the bus with an active-low acknowledge only when exactly one unit is asking. When two or more units ask at the same moment, it withholds the grant and pulls an active-low collision line that every unit sees. Requests are never ranked by priority.

On a device that is not the master, or when a strap hands arbitration to external logic, the acknowledge and collision lines are inputs that the block only observes. In that case the number of stacked units is not limited by the three request inputs. In every mode the block tells the local repeater whether to drive the shared data lines (it asked and was granted) or to listen to them (someone else was granted). It also provides the enables for the acknowledge and collision pads, so a device that is not arbitrating never drives those lines. The data path, bus clocking and pad drivers lie outside the block.

Top module: `stack_bus_arbiter`

## Requirements
- R1: After reset, ack_n_out and col_n_out are 1, and req_out, dat_oe and rx_en are 0.
- R2: When the arbiter is enabled (master_sel=1, ext_arb=0) and exactly one of the four requests is active (req_out and the three bits of req_in), ack_n_out is 0 and col_n_out is 1.
- R3: When the arbiter is enabled and two or more of the four requests are active, ack_n_out is 1 and col_n_out is 0. ack_n_out and col_n_out are never both 0.
- R4: When the arbiter is enabled and no request is active, ack_n_out and col_n_out are both 1.
- R5: ack_oe and col_oe are 1 exactly when master_sel=1 and ext_arb=0. Otherwise ack_n_out and col_n_out stay at 1 whatever req_in is.
- R6: req_out takes the value local_req had at the previous rising clock edge.
- R7: dat_oe is 1 when the device requested and sees acknowledge low with collision high. rx_en is 1 when it did not request and sees acknowledge low with collision high. The two are never 1 together.
- R8: When the arbiter is disabled, the acknowledge and collision the device acts on come from ack_n_in and col_n_in, each passed through two synchronizer flops, so dat_oe and rx_en follow them three edges later.
- R9: A change on req_in reaches ack_n_out/col_n_out at the third rising edge after it. A change on local_req reaches them at the second edge, and reaches dat_oe at the third.
- R10: When a collision resolves to a single remaining requester, col_n_out returns to 1 and ack_n_out goes to 0 for that requester, without passing through idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| master_sel | input | 1 | Strap: this device arbitrates the stack |
| ext_arb | input | 1 | Strap: arbitration is done by external logic |
| local_req | input | 1 | Local repeater wants the bus |
| req_in | input | EXT_REQS | Request lines from other units (asynchronous) |
| ack_n_in | input | 1 | Acknowledge seen on the bus, active low (asynchronous) |
| col_n_in | input | 1 | Collision seen on the bus, active low (asynchronous) |
| req_out | output | 1 | This unit's request to the bus |
| ack_n_out | output | 1 | Acknowledge driven by the arbiter, active low |
| col_n_out | output | 1 | Collision driven by the arbiter, active low |
| ack_oe | output | 1 | Pad enable for acknowledge |
| col_oe | output | 1 | Pad enable for collision |
| dat_oe | output | 1 | Local repeater drives the shared data lines |
| rx_en | output | 1 | Local repeater receives from the shared data lines |

## Verification
The hardest case to reach from the ports is a collision that resolves to exactly one survivor, where acknowledge must come back without an idle cycle in between. The survivor can be the local request, which takes a different number of register stages than the synchronized external ones. The bench reaches this with directed sequences that drop requests one at a time from a multi-way collision. It also walks all sixteen four-bit request patterns, including the local bit, and adds seeded random pattern sequences. On a device that is not the master, it drives req_in at random to show that those lines have no effect.

// File: rtl/stack_arb_pkg.sv
package stack_arb_pkg;

    localparam int EXT_REQS   = 3;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        VERD_IDLE    = 2'd0,
        VERD_GRANT   = 2'd1,
        VERD_COLLIDE = 2'd2
    } verdict_e;

    typedef struct packed {
        logic ack_n;
        logic col_n;
    } line_pair_t;

    localparam line_pair_t LINES_IDLE = '{ack_n: 1'b1, col_n: 1'b1};

    function automatic verdict_e verdict_of(input int unsigned active);
        if (active == 0)      return VERD_IDLE;
        else if (active == 1) return VERD_GRANT;
        else                  return VERD_COLLIDE;
    endfunction

    function automatic line_pair_t lines_of(input verdict_e v);
        line_pair_t l;
        l = LINES_IDLE;
        case (v)
            VERD_GRANT:   l.ack_n = 1'b0;
            VERD_COLLIDE: l.col_n = 1'b0;
            default:      l = LINES_IDLE;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/stk_sync.sv
module stk_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= RST_VAL;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= RST_VAL;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/stk_judge.sv
module stk_judge
    import stack_arb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] reqs,
    output line_pair_t   lines
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] active;
    verdict_e      verdict;

    always_comb begin
        active = '0;
        for (int i = 0; i < N; i++) begin
            active = active + CW'(reqs[i]);
        end
        verdict = verdict_of(int'(active));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) lines <= LINES_IDLE;
        else            lines <= lines_of(verdict);
    end
endmodule

// File: rtl/stk_director.sv
module stk_director
    import stack_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       asked,
    input  line_pair_t seen,
    output logic       dat_oe,
    output logic       rx_en
);
    logic granted;
    assign granted = !seen.ack_n && seen.col_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_oe <= 1'b0;
            rx_en  <= 1'b0;
        end else begin
            dat_oe <= granted && asked;
            rx_en  <= granted && !asked;
        end
    end
endmodule

// File: rtl/stack_bus_arbiter.sv
module stack_bus_arbiter
    import stack_arb_pkg::*;
#(
    parameter int EXT = stack_arb_pkg::EXT_REQS,
    parameter int SYN = stack_arb_pkg::SYNC_DEPTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           master_sel,
    input  logic           ext_arb,
    input  logic           local_req,
    input  logic [EXT-1:0] req_in,
    input  logic           ack_n_in,
    input  logic           col_n_in,
    output logic           req_out,
    output logic           ack_n_out,
    output logic           col_n_out,
    output logic           ack_oe,
    output logic           col_oe,
    output logic           dat_oe,
    output logic           rx_en
);
    localparam int ALL = EXT + 1;

    logic           arb_en;
    logic [EXT-1:0] req_sync;
    logic [1:0]     bus_sync;
    logic           req_q;
    line_pair_t     judged;
    line_pair_t     observed;
    line_pair_t     seen;

    assign arb_en = master_sel && !ext_arb;

    stk_sync #(.W(EXT), .STAGES(SYN), .RST_VAL('0)) u_req_sync (
        .clk(clk), .rst(rst), .d(req_in), .q(req_sync)
    );

    stk_sync #(.W(2), .STAGES(SYN), .RST_VAL(2'b11)) u_line_sync (
        .clk(clk), .rst(rst), .d({ack_n_in, col_n_in}), .q(bus_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= local_req;
    end

    stk_judge #(.N(ALL)) u_judge (
        .clk(clk), .rst(rst), .en(arb_en),
        .reqs({req_sync, req_q}), .lines(judged)
    );

    assign observed = '{ack_n: bus_sync[1], col_n: bus_sync[0]};
    assign seen     = arb_en ? judged : observed;

    stk_director u_dir (
        .clk(clk), .rst(rst), .asked(req_q), .seen(seen),
        .dat_oe(dat_oe), .rx_en(rx_en)
    );

    assign req_out   = req_q;
    assign ack_oe    = arb_en;
    assign col_oe    = arb_en;
    assign ack_n_out = judged.ack_n || !arb_en;
    assign col_n_out = judged.col_n || !arb_en;
endmodule

// File: rtl/stack_bus_arbiter_chk.sv
module stack_bus_arbiter_chk (
    input logic clk,
    input logic rst,
    input logic master_sel,
    input logic ext_arb,
    input logic local_req,
    input logic req_out,
    input logic ack_n_out,
    input logic col_n_out,
    input logic ack_oe,
    input logic dat_oe,
    input logic rx_en
);
    AST_ACK_COL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!ack_n_out && !col_n_out)); // R3

    AST_QUIET_WHEN_PASSIVE: assert property (@(posedge clk) disable iff (rst)
        !(master_sel && !ext_arb) |-> (ack_n_out && col_n_out && !ack_oe)); // R5

    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        local_req |=> req_out); // R6

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        !local_req |=> !req_out); // R6

    AST_DRIVE_RX_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dat_oe && rx_en)); // R7

    AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        dat_oe |-> $past(req_out)); // R7
endmodule

bind stack_bus_arbiter stack_bus_arbiter_chk u_chk (
    .clk(clk), .rst(rst), .master_sel(master_sel), .ext_arb(ext_arb),
    .local_req(local_req), .req_out(req_out), .ack_n_out(ack_n_out),
    .col_n_out(col_n_out), .ack_oe(ack_oe), .dat_oe(dat_oe), .rx_en(rx_en)
);

// File: tb/stack_bus_arbiter_tb.sv
module stack_bus_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       master_sel = 1'b1;
    logic       ext_arb = 1'b0;
    logic       local_req = 1'b0;
    logic [2:0] req_in = 3'b000;
    logic       ack_n_in = 1'b1;
    logic       col_n_in = 1'b1;
    logic       req_out, ack_n_out, col_n_out, ack_oe, col_oe, dat_oe, rx_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_bus_arbiter dut_i (
        .clk(clk), .rst(rst), .master_sel(master_sel), .ext_arb(ext_arb),
        .local_req(local_req), .req_in(req_in), .ack_n_in(ack_n_in),
        .col_n_in(col_n_in), .req_out(req_out), .ack_n_out(ack_n_out),
        .col_n_out(col_n_out), .ack_oe(ack_oe), .col_oe(col_oe),
        .dat_oe(dat_oe), .rx_en(rx_en)
    );

    function automatic int ones4(input logic [3:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
    endfunction

    function automatic logic exp_ack_n(input logic [3:0] v);
        return (ones4(v) == 1) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic exp_col_n(input logic [3:0] v);
        return (ones4(v) >= 2) ? 1'b0 : 1'b1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic drive_master(input logic [3:0] pat);
        @(negedge clk);
        local_req = pat[0];
        req_in    = pat[3:1];
        settle();
    endtask

    task automatic check_master(input string req, input logic [3:0] pat);
        logic g;
        g = (ones4(pat) == 1);
        check(req, "ack_n_out", ack_n_out, exp_ack_n(pat));
        check(req, "col_n_out", col_n_out, exp_col_n(pat));
        check("R7", "dat_oe", dat_oe, g && pat[0]);
        check("R7", "rx_en", rx_en, g && !pat[0]);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "ack_n_out", ack_n_out, 1'b1);
        check("R1", "col_n_out", col_n_out, 1'b1);
        check("R1", "req_out", req_out, 1'b0);
        check("R1", "dat_oe", dat_oe, 1'b0);
        check("R1", "rx_en", rx_en, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        settle();
        // R4: idle with no requests, R5 enables in master mode
        check("R4", "ack_n_out", ack_n_out, 1'b1);
        check("R4", "col_n_out", col_n_out, 1'b1);
        check("R5", "ack_oe", ack_oe, 1'b1);
        check("R5", "col_oe", col_oe, 1'b1);

        // R2 R3 R4: every four-bit request pattern
        for (int p = 0; p < 16; p++) begin
            drive_master(4'(p));
            check_master(ones4(4'(p)) == 0 ? "R4" :
                         (ones4(4'(p)) == 1 ? "R2" : "R3"), 4'(p));
        end

        // R9: external request latency of three edges
        drive_master(4'b0000);
        @(negedge clk);
        req_in = 3'b010;
        @(posedge clk); @(posedge clk); #1;
        check("R9", "ack_n_out after 2 edges", ack_n_out, 1'b1);
        @(posedge clk); #1;
        check("R9", "ack_n_out after 3 edges", ack_n_out, 1'b0);

        // R6 R9: local request latency
        drive_master(4'b0000);
        @(negedge clk);
        local_req = 1'b1;
        @(posedge clk); #1;
        check("R6", "req_out after 1 edge", req_out, 1'b1);
        check("R9", "ack_n_out after 1 edge", ack_n_out, 1'b1);
        @(posedge clk); #1;
        check("R9", "ack_n_out after 2 edges", ack_n_out, 1'b0);
        check("R9", "dat_oe after 2 edges", dat_oe, 1'b0);
        @(posedge clk); #1;
        check("R9", "dat_oe after 3 edges", dat_oe, 1'b1);
        @(negedge clk);
        local_req = 1'b0;
        @(posedge clk); #1;
        check("R6", "req_out drop", req_out, 1'b0);

        // R10: collision resolving to one survivor, never idle between
        drive_master(4'b1011);
        check_master("R3", 4'b1011);
        drive_master(4'b1001);
        check_master("R3", 4'b1001);
        begin
            int idle_seen;
            idle_seen = 0;
            @(negedge clk);
            req_in = 3'b000;
            for (int k = 0; k < 6; k++) begin
                @(posedge clk); #1;
                if (ack_n_out && col_n_out) idle_seen++;
            end
            check("R10", "idle cycles during resolve", idle_seen != 0, 1'b0);
            check("R10", "ack_n_out survivor", ack_n_out, 1'b0);
            check("R10", "col_n_out released", col_n_out, 1'b1);
            check("R10", "dat_oe survivor", dat_oe, 1'b1);
        end
        drive_master(4'b0110);
        drive_master(4'b0100);
        check_master("R10", 4'b0100);

        // R2 R3 R4: random pattern sequences
        for (int n = 0; n < 60; n++) begin
            logic [3:0] pat;
            pat = 4'($urandom_range(0, 15));
            drive_master(pat);
            check_master(ones4(pat) == 1 ? "R2" :
                         (ones4(pat) == 0 ? "R4" : "R3"), pat);
        end

        // R5 R8: passive modes, slave and external arbiter
        for (int n = 0; n < 40; n++) begin
            logic lr, an, cn;
            lr = 1'($urandom_range(0, 1));
            an = 1'($urandom_range(0, 1));
            cn = 1'($urandom_range(0, 1));
            @(negedge clk);
            if (n < 20) begin master_sel = 1'b0; ext_arb = 1'($urandom_range(0, 1)); end
            else        begin master_sel = 1'b1; ext_arb = 1'b1; end
            local_req = lr;
            req_in    = 3'($urandom_range(0, 7));
            ack_n_in  = an;
            col_n_in  = cn;
            settle();
            check("R5", "ack_oe passive", ack_oe, 1'b0);
            check("R5", "col_oe passive", col_oe, 1'b0);
            check("R5", "ack_n_out passive", ack_n_out, 1'b1);
            check("R5", "col_n_out passive", col_n_out, 1'b1);
            check("R8", "dat_oe from bus", dat_oe, lr && !an && cn);
            check("R8", "rx_en from bus", rx_en, !lr && !an && cn);
        end

        // R8: three-edge latency from bus acknowledge to receive enable
        @(negedge clk);
        master_sel = 1'b0; ext_arb = 1'b0; local_req = 1'b0;
        ack_n_in = 1'b1; col_n_in = 1'b1;
        settle();
        @(negedge clk);
        ack_n_in = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R8", "rx_en after 2 edges", rx_en, 1'b0);
        @(posedge clk); #1;
        check("R8", "rx_en after 3 edges", rx_en, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule